// File: doc/BRIEF.md
# Datapath Reset Sequencer

This block resets one MAC datapath (transmit or receive) safely when asked to, without software walking through each step. A single start request makes it disable the path and wait until the path reports that no transfer is in flight. If the path stays busy too long, it gives up waiting, carries on, and raises a sticky flag. It then drives the path reset low for a minimum number of cycles and keeps it low until the clock-stable indication is true. After release it waits a settling time given in nanoseconds. It then pulses a clear to the statistics counters and re-enables the path with a one-cycle done pulse.

The reset is presented in two forms: an active-low reset line, and a reset-control word image. In that word, bit 0 is the transmit reset and bit 8 is the receive reset. A parameter picks which path the instance serves. The busy indication is taken from bit 8 of the path's transfer-status word.

Top module: `dp_reset_seq`

## Requirements
- R1: While and after synchronous reset `rst`, path_disable_o=0, path_rst_n_o=1, rst_word_o=0, stats_clr_o=0, done_o=0 and drain_to_o=0.
- R2: A start_i sampled high while idle sets path_disable_o to 1 at that same clock edge. path_rst_n_o stays 1 at that edge.
- R3: During the drain phase, only bit 8 of xfer_status_i is examined, and all other bits are ignored. The first edge at which bit 8 is sampled 0 ends the drain. The drain lasts at most DRAIN_TIMEOUT cycles counted from the start edge, so its length is min(b+1, DRAIN_TIMEOUT) when bit 8 reads 1 for the first b sampled cycles.
- R4: If bit 8 is still 1 at the DRAIN_TIMEOUT-th cycle, the sequence continues and drain_to_o becomes 1. drain_to_o then holds until the next accepted start, which clears it at the start edge.
- R5: path_rst_n_o is held low for at least HOLD_CYCLES cycles. It is held low for exactly HOLD_CYCLES cycles when clk_stable_i is 1 throughout.
- R6: path_rst_n_o is released only at an edge where clk_stable_i is sampled 1. If clk_stable_i first reads 1 at the (L+1)-th hold edge, the low time is max(HOLD_CYCLES, L+1).
- R7: rst_word_o has exactly one bit set while path_rst_n_o is low, and all bits zero otherwise. The set bit is bit 0 when PATH_RX=0 and bit 8 when PATH_RX=1.
- R8: After release, path_rst_n_o stays high for ceil(SETTLE_NS*1000/CLK_PERIOD_PS) cycles before stats_clr_o rises. stats_clr_o is high for exactly one cycle.
- R9: In the cycle after the clear pulse, path_disable_o returns to 0 and done_o is 1 for exactly one cycle.
- R10: start_i is ignored from the start edge until the sequencer is idle again, including the done cycle. A start in that window neither restarts, stretches nor shortens any phase, and it does not clear drain_to_o.
- R11: path_disable_o stays 1 from the start edge through the clear pulse, so the path reset is never asserted while the path is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the sequencer |
| start_i | input | 1 | Request to run one reset sequence |
| xfer_status_i | input | STAT_W | Path transfer-status word; bit 8 = transfer in progress |
| clk_stable_i | input | 1 | Path clock is stable |
| path_disable_o | output | 1 | Path disable (control bit 0 image) |
| path_rst_n_o | output | 1 | Active-low path reset |
| rst_word_o | output | WORD_W | Reset-control word image (bit 0 TX, bit 8 RX) |
| stats_clr_o | output | 1 | One-cycle statistics clear pulse |
| done_o | output | 1 | One-cycle pulse at re-enable |
| drain_to_o | output | 1 | Sticky drain-timeout flag |

## Verification
The assertions assume clk_stable_i eventually goes high during the hold phase. Otherwise the release and clear properties are never reached. They also assume start_i is a plain level that the sequencer samples, not a handshake that must be held. The stimulus keeps clk_stable_i high except for a bounded lag of up to a few cycles after the reset falls. It drives bit 8 busy for random spans below, at and beyond the timeout, with random values in the other status bits. It also scatters random start requests through each running sequence and into the done cycle.

// File: rtl/seqr_pkg.sv
package seqr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_DRAIN  = 3'd1,
    ST_HOLD   = 3'd2,
    ST_SETTLE = 3'd3,
    ST_CLEAR  = 3'd4,
    ST_RESUME = 3'd5
  } seq_state_t;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/seq_timer.sv
// Loadable down counter shared by all timed phases of the sequencer.
module seq_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // never counts up except through a load
  a_r5_timer_down: assert property (@(posedge clk) disable iff (rst)
    !$past(load) && $past(cnt_q) != '0 |-> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/rst_word_map.sv
// Places the registered reset request on the word bit owned by the chosen path.
module rst_word_map #(
  parameter int WORD_W  = 16,
  parameter bit PATH_RX = 1'b0,
  parameter int TX_BIT  = 0,
  parameter int RX_BIT  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              assert_nxt,
  output logic [WORD_W-1:0] word_o
);
  localparam int SEL_BIT = PATH_RX ? RX_BIT : TX_BIT;

  generate
    for (genvar i = 0; i < WORD_W; i++) begin : g_bit
      if (i == SEL_BIT) begin : g_live
        always_ff @(posedge clk) begin
          if (rst) word_o[i] <= 1'b0;
          else     word_o[i] <= assert_nxt;
        end
      end else begin : g_tied
        assign word_o[i] = 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/seq_fsm.sv
// Phase controller: quiesce, drain, hold, settle, clear, resume.
module seq_fsm
  import seqr_pkg::*;
#(
  parameter int TMR_W         = 8,
  parameter int DRAIN_TIMEOUT = 64,
  parameter int HOLD_CYCLES   = 3,
  parameter int SETTLE_CYCLES = 79
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             busy_i,
  input  logic             clk_stable_i,
  input  logic             tmr_expired,
  output logic             tmr_load,
  output logic [TMR_W-1:0] tmr_val,
  output logic             rst_assert_nxt,
  output logic             path_disable_o,
  output logic             path_rst_n_o,
  output logic             stats_clr_o,
  output logic             done_o,
  output logic             drain_to_o
);
  localparam logic [TMR_W-1:0] DRAIN_LD  = TMR_W'(DRAIN_TIMEOUT - 1);
  localparam logic [TMR_W-1:0] HOLD_LD   = TMR_W'(HOLD_CYCLES - 1);
  localparam logic [TMR_W-1:0] SETTLE_LD = TMR_W'(SETTLE_CYCLES - 1);

  seq_state_t st_q, st_nxt;
  logic set_to, clr_to;

  always_comb begin
    st_nxt   = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    set_to   = 1'b0;
    clr_to   = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        st_nxt   = ST_DRAIN;
        tmr_load = 1'b1;
        tmr_val  = DRAIN_LD;
        clr_to   = 1'b1;
      end
      ST_DRAIN: if (!busy_i || tmr_expired) begin
        st_nxt   = ST_HOLD;
        tmr_load = 1'b1;
        tmr_val  = HOLD_LD;
        set_to   = busy_i;
      end
      ST_HOLD: if (tmr_expired && clk_stable_i) begin
        st_nxt   = ST_SETTLE;
        tmr_load = 1'b1;
        tmr_val  = SETTLE_LD;
      end
      ST_SETTLE: if (tmr_expired) st_nxt = ST_CLEAR;
      ST_CLEAR:  st_nxt = ST_RESUME;
      ST_RESUME: st_nxt = ST_IDLE;
      default:   st_nxt = ST_IDLE;
    endcase
  end

  assign rst_assert_nxt = (st_nxt == ST_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q           <= ST_IDLE;
      path_disable_o <= 1'b0;
      path_rst_n_o   <= 1'b1;
      stats_clr_o    <= 1'b0;
      done_o         <= 1'b0;
      drain_to_o     <= 1'b0;
    end else begin
      st_q           <= st_nxt;
      path_disable_o <= (st_nxt == ST_DRAIN) || (st_nxt == ST_HOLD) ||
                        (st_nxt == ST_SETTLE) || (st_nxt == ST_CLEAR);
      path_rst_n_o   <= (st_nxt != ST_HOLD);
      stats_clr_o    <= (st_nxt == ST_CLEAR);
      done_o         <= (st_nxt == ST_RESUME);
      if (clr_to)      drain_to_o <= 1'b0;
      else if (set_to) drain_to_o <= 1'b1;
    end
  end

  // checker counters for windows whose length is a parameter
  logic [15:0] low_cnt_q, high_cnt_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt_q  <= '0;
      high_cnt_q <= '0;
    end else begin
      low_cnt_q  <= !path_rst_n_o ? ((low_cnt_q == 16'hFFFF) ? low_cnt_q : low_cnt_q + 1'b1) : '0;
      high_cnt_q <= (!path_rst_n_o || !path_disable_o) ? '0 :
                    ((high_cnt_q == 16'hFFFF) ? high_cnt_q : high_cnt_q + 1'b1);
    end
  end

  a_r5_hold_min: assert property (@(posedge clk) disable iff (rst)
    $rose(path_rst_n_o) |-> low_cnt_q >= 16'(HOLD_CYCLES));
  a_r6_release_stable: assert property (@(posedge clk) disable iff (rst)
    $rose(path_rst_n_o) |-> $past(clk_stable_i));
  a_r8_settle_len: assert property (@(posedge clk) disable iff (rst)
    $rose(stats_clr_o) |-> high_cnt_q >= 16'(SETTLE_CYCLES));
  a_r8_clr_pulse: assert property (@(posedge clk) disable iff (rst)
    stats_clr_o |=> !stats_clr_o);
  a_r9_done_after_clr: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !path_disable_o && $past(stats_clr_o));
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  a_r11_rst_disabled: assert property (@(posedge clk) disable iff (rst)
    !path_rst_n_o |-> path_disable_o);
  a_r4_sticky: assert property (@(posedge clk) disable iff (rst)
    $fell(drain_to_o) |-> $past(start_i) && $rose(path_disable_o));
  a_r2_start_disables: assert property (@(posedge clk) disable iff (rst)
    $rose(path_disable_o) |-> $past(start_i));
endmodule

// File: rtl/dp_reset_seq.sv
module dp_reset_seq
  import seqr_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 6400,
  parameter int SETTLE_NS     = 500,
  parameter int HOLD_CYCLES   = 3,
  parameter int DRAIN_TIMEOUT = 64,
  parameter bit PATH_RX       = 1'b0,
  parameter int STAT_W        = 16,
  parameter int BUSY_BIT      = 8,
  parameter int WORD_W        = 16,
  parameter int TX_RST_BIT    = 0,
  parameter int RX_RST_BIT    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [STAT_W-1:0] xfer_status_i,
  input  logic              clk_stable_i,
  output logic              path_disable_o,
  output logic              path_rst_n_o,
  output logic [WORD_W-1:0] rst_word_o,
  output logic              stats_clr_o,
  output logic              done_o,
  output logic              drain_to_o
);
  localparam int SETTLE_CYCLES = ceil_div(SETTLE_NS * 1000, CLK_PERIOD_PS);
  localparam int TMR_MAX       = max3(DRAIN_TIMEOUT, HOLD_CYCLES, SETTLE_CYCLES);
  localparam int TMR_W         = $clog2(TMR_MAX + 1);

  logic             tmr_load, tmr_expired, rst_assert_nxt;
  logic [TMR_W-1:0] tmr_val;

  seq_timer #(.W(TMR_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  seq_fsm #(
    .TMR_W         (TMR_W),
    .DRAIN_TIMEOUT (DRAIN_TIMEOUT),
    .HOLD_CYCLES   (HOLD_CYCLES),
    .SETTLE_CYCLES (SETTLE_CYCLES)
  ) u_fsm (
    .clk            (clk),
    .rst            (rst),
    .start_i        (start_i),
    .busy_i         (xfer_status_i[BUSY_BIT]),
    .clk_stable_i   (clk_stable_i),
    .tmr_expired    (tmr_expired),
    .tmr_load       (tmr_load),
    .tmr_val        (tmr_val),
    .rst_assert_nxt (rst_assert_nxt),
    .path_disable_o (path_disable_o),
    .path_rst_n_o   (path_rst_n_o),
    .stats_clr_o    (stats_clr_o),
    .done_o         (done_o),
    .drain_to_o     (drain_to_o)
  );

  rst_word_map #(
    .WORD_W  (WORD_W),
    .PATH_RX (PATH_RX),
    .TX_BIT  (TX_RST_BIT),
    .RX_BIT  (RX_RST_BIT)
  ) u_word (
    .clk        (clk),
    .rst        (rst),
    .assert_nxt (rst_assert_nxt),
    .word_o     (rst_word_o)
  );

  // word image and reset line come from separate registers
  a_r7_word_tracks: assert property (@(posedge clk) disable iff (rst)
    $countones(rst_word_o) == (path_rst_n_o ? 0 : 1));
  a_r7_word_bit: assert property (@(posedge clk) disable iff (rst)
    !path_rst_n_o |-> rst_word_o[PATH_RX ? RX_RST_BIT : TX_RST_BIT]);
endmodule

// File: tb/dp_reset_seq_bench.sv
module dp_reset_seq_bench;
  localparam int T_CLK  = 10;
  localparam int HC     = 3;
  localparam int TO     = 64;
  localparam int PER_PS = 6400;
  localparam int SET_NS = 500;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] status = '0;
  logic        stable = 1'b1;
  logic        dis, rstn, clr, done, to_flag;
  logic [15:0] rword;
  logic        t_dis, t_rstn, t_clr, t_done, t_to;
  logic [15:0] t_rword;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(T_CLK/2) clk = ~clk;

  dp_reset_seq #(.CLK_PERIOD_PS(PER_PS), .SETTLE_NS(SET_NS), .HOLD_CYCLES(HC),
                 .DRAIN_TIMEOUT(TO), .PATH_RX(1'b1)) u_dp_reset_seq (
    .clk(clk), .rst(rst), .start_i(start), .xfer_status_i(status),
    .clk_stable_i(stable), .path_disable_o(dis), .path_rst_n_o(rstn),
    .rst_word_o(rword), .stats_clr_o(clr), .done_o(done), .drain_to_o(to_flag));

  dp_reset_seq #(.CLK_PERIOD_PS(PER_PS), .SETTLE_NS(SET_NS), .HOLD_CYCLES(HC),
                 .DRAIN_TIMEOUT(TO), .PATH_RX(1'b0)) u_dp_reset_seq_tx (
    .clk(clk), .rst(rst), .start_i(start), .xfer_status_i(status),
    .clk_stable_i(stable), .path_disable_o(t_dis), .path_rst_n_o(t_rstn),
    .rst_word_o(t_rword), .stats_clr_o(t_clr), .done_o(t_done), .drain_to_o(t_to));

  function automatic int exp_settle();
    return (SET_NS * 1000 + PER_PS - 1) / PER_PS;
  endfunction
  function automatic int exp_drain(int b);
    return (b + 1 < TO) ? b + 1 : TO;
  endfunction
  function automatic int exp_hold(int l);
    return (l + 1 > HC) ? l + 1 : HC;
  endfunction
  function automatic bit words_ok();
    return (rword == (rstn ? 16'h0000 : 16'h0100)) &&
           (t_rword == (t_rstn ? 16'h0000 : 16'h0001));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_busy(input bit b);
    status = 16'($urandom);
    status[8] = b;
  endtask

  task automatic run_seq(input int busy, input int lag, input bit spam, input bit tail_start);
    bit w_ok = 1'b1;
    bit d_ok = 1'b1;
    int j = 0;
    int m = 0;
    int c = 0;
    bit exp_to;
    exp_to = (busy >= TO);
    @(negedge clk);
    start = 1'b1;
    set_busy(busy >= 1);
    @(negedge clk);
    start = spam ? 1'($urandom) : 1'b0;
    chk(dis == 1'b1 && rstn == 1'b1, "R2 disable at start", int'(dis), 1);
    chk(to_flag == 1'b0, "R4 flag cleared by start", int'(to_flag), 0);
    // drain phase
    while (1) begin
      set_busy(j + 1 <= busy);
      if (spam) start = 1'($urandom);
      @(negedge clk);
      j++;
      w_ok &= words_ok();
      d_ok &= dis;
      if (!rstn || j > 500) break;
    end
    chk(j == exp_drain(busy), "R3 drain length", j, exp_drain(busy));
    chk(to_flag == exp_to && t_to == exp_to, "R4 timeout flag", int'(to_flag), int'(exp_to));
    // hold phase
    while (1) begin
      stable = (m >= lag);
      if (spam) start = 1'($urandom);
      @(negedge clk);
      m++;
      w_ok &= words_ok();
      d_ok &= dis;
      if (rstn || m > 500) break;
    end
    stable = 1'b1;
    chk(m == exp_hold(lag), (lag == 0) ? "R5 hold length" : "R6 release waits stable",
        m, exp_hold(lag));
    // settle phase
    while (!clr && c < 1000) begin
      if (spam) start = 1'($urandom);
      w_ok &= words_ok() && rstn;
      d_ok &= dis;
      c++;
      @(negedge clk);
    end
    start = 1'b0;
    chk(c == exp_settle(), "R8 settle length", c, exp_settle());
    chk(dis == 1'b1 && rstn == 1'b1, "R11 disabled during clear", int'(dis), 1);
    @(negedge clk);
    chk(clr == 1'b0, "R8 clear one cycle", int'(clr), 0);
    chk(done == 1'b1 && dis == 1'b0 && t_done == 1'b1, "R9 done and re-enable", int'(done), 1);
    if (tail_start) start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0 && dis == 1'b0, "R9 done one cycle", int'(done), 0);
    if (tail_start || spam)
      chk(dis == 1'b0 && to_flag == exp_to, "R10 start ignored while running", int'(dis), 0);
    chk(w_ok, "R7 reset word image", int'(w_ok), 1);
    chk(d_ok, "R11 disable held", int'(d_ok), 1);
    repeat (3) @(negedge clk);
    chk(to_flag == exp_to && dis == 1'b0, "R4 flag sticky while idle", int'(to_flag), int'(exp_to));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(dis == 0 && rstn == 1 && rword == 0 && clr == 0 && done == 0 && to_flag == 0,
        "R1 reset state", int'(dis), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(dis == 0 && rstn == 1 && t_rword == 0, "R1 idle after reset", int'(rstn), 1);
    // directed corners
    run_seq(0, 0, 1'b0, 1'b0);
    run_seq(TO - 1, 0, 1'b0, 1'b1);
    run_seq(TO, 0, 1'b0, 1'b0);
    run_seq(TO + 20, 6, 1'b1, 1'b0);
    run_seq(2, HC - 1, 1'b0, 1'b1);
    run_seq(1, HC, 1'b1, 1'b1);
    // random mix
    for (int i = 0; i < 24; i++)
      run_seq(int'($urandom_range(0, TO + 10)), int'($urandom_range(0, 6)),
              1'($urandom), 1'($urandom));
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(T_CLK * 200000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule